// File: doc/BRIEF.md
# Paced Receive Word Buffer

This block sits between the receive side of a serial port and a host DMA engine. It buffers 32-bit words and changes the rhythm of requests. Each request from the port makes the buffer pull a programmable burst of words from the port. The pull waits until the buffer has room for the whole burst. Toward the host, the buffer raises a single request only when its fill level reaches a programmable event threshold. It then waits for an acknowledge and for that many host reads before it looks at the fill level again. A processor can read words at any time through a separate strobe, and can drain a buffer that holds less than one event's worth.

With the enable input low, the block is a plain wire path. The port request goes straight to the host, the host read strobe goes straight to the port, and the port data goes straight to the read data output. Disabling also empties the buffer and clears all pending state. To turn pacing off, set the event threshold equal to the burst size. A threshold that is a non-zero multiple of the burst size gives one host request per that many bursts.

Top module: `rx_pacer_fifo`

## Requirements
- R1: While `cfg_enable` is 0, `host_req` equals `port_req`, `port_rd` equals `host_rd` and `rd_data` equals `port_data`. Each clock edge with `cfg_enable` at 0 discards all stored words and all pending requests.
- R2: A `port_req` sampled high at edge N sets a pending request. At edge N+1 a fetch starts if `DEPTH` minus occupancy is at least `cfg_dma_count`. `port_rd` is then high for exactly `cfg_dma_count` consecutive cycles, and one `port_data` word is stored at each edge where `port_rd` is high.
- R3: If space is short when a request is pending, no word is fetched. The fetch starts at the first edge where free space is at least `cfg_dma_count`, and occupancy never exceeds `DEPTH`.
- R4: When no host request is outstanding and no host burst is in progress, and occupancy at an edge is at least a non-zero `cfg_evt_count`, `host_req` goes high after that edge. It stays high until an edge where `host_ack` is 1.
- R5: After the acknowledging edge, `host_req` stays low until `cfg_evt_count` words have been removed by `host_rd`. Occupancy is then tested again, and a new request follows if enough words remain.
- R6: `rd_data` presents the oldest stored word. Each edge with `host_rd` or `cpu_rd` high removes one word, even when both are high. Words leave in arrival order, and CPU reads may empty the buffer at any fill level.
- R7: With the buffer empty, `rd_data` is 0, and a read strobe changes no state.
- R8: At most one port request is held. Port requests arriving while one is already pending are dropped.
- R9: With `cfg_evt_count` equal to `cfg_dma_count`, each fetched burst leads to exactly one host request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1 buffers and paces, 0 passes through |
| cfg_evt_count | input | CW | Host event threshold in words |
| cfg_dma_count | input | CW | Words fetched per port request |
| port_req | input | 1 | Receive request from the serial port |
| port_rd | output | 1 | Word read strobe to the port |
| port_data | input | DATA_W | Word from the port, valid while port_rd is high |
| host_req | output | 1 | Receive request to the host DMA |
| host_ack | input | 1 | Host response to host_req |
| host_rd | input | 1 | Host DMA read strobe |
| cpu_rd | input | 1 | Direct processor read strobe |
| rd_data | output | DATA_W | Oldest stored word, or 0 when empty |

## Verification
A wrong occupancy count shows at the ports within one cycle. `host_req` rises one edge too early or too late against the threshold, or a stalled fetch starts while free space is still below the burst size. A misplaced read pointer changes `rd_data` at once, because the head word is visible without delay. A burst counter that is off by one shows on `port_rd`, which is high for one cycle too many or too few, or as an early or late re-request after a host burst. The bench model follows all of this from the port signals alone and compares all three outputs every cycle.

// File: rtl/rx_pacer_fifo.sv
module rx_pacer_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [CW-1:0]     cfg_evt_count,
  input  logic [CW-1:0]     cfg_dma_count,
  input  logic              port_req,
  output logic              port_rd,
  input  logic [DATA_W-1:0] port_data,
  output logic              host_req,
  input  logic              host_ack,
  input  logic              host_rd,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, fetch_left, burst_left;
  logic pend_q, hreq_q, busy_q;

  wire          fetching = fetch_left != '0;
  wire          push     = cfg_enable && fetching;
  wire          pop      = cfg_enable && (host_rd || cpu_rd) && count != '0;
  wire [CW-1:0] space    = CW'(DEPTH) - count;
  wire          start    = pend_q && !fetching && space >= cfg_dma_count;
  wire          idle     = !hreq_q && !busy_q;

  assign port_rd  = cfg_enable ? fetching : host_rd;
  assign host_req = cfg_enable ? hreq_q : port_req;
  assign rd_data  = !cfg_enable ? port_data : (count != '0 ? mem[rptr] : '0);

  always_ff @(posedge clk)
    if (push) mem[wptr] <= port_data;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_enable) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      fetch_left <= '0;
      burst_left <= '0;
      pend_q     <= 1'b0;
      hreq_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      wptr  <= wptr + AW'(push);
      rptr  <= rptr + AW'(pop);
      count <= count + CW'(push) - CW'(pop);

      if (start)         fetch_left <= cfg_dma_count;
      else if (fetching) fetch_left <= fetch_left - 1'b1;
      pend_q <= start ? port_req : (pend_q | port_req);

      if (idle && cfg_evt_count != '0 && count >= cfg_evt_count) begin
        hreq_q <= 1'b1;
      end else if (hreq_q && host_ack) begin
        hreq_q     <= 1'b0;
        busy_q     <= 1'b1;
        burst_left <= cfg_evt_count;
      end else if (busy_q && host_rd && count != '0) begin
        burst_left <= burst_left - 1'b1;
        if (burst_left <= 1) busy_q <= 1'b0;
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && port_rd) |-> count < CW'(DEPTH));

  assert_burst_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
    fetching |=> fetch_left == $past(fetch_left) - 1'b1);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
    (host_req && !host_ack) |=> host_req);

  assert_quiet_busy_R5: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
    busy_q |-> !host_req);

  assert_empty_stays_R7: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
    (count == '0 && !port_rd) |=> count == '0);

endmodule

// File: tb/rx_pacer_fifo_tb.sv
`timescale 1ns/1ps
module rx_pacer_fifo_tb;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, en = 1;
  logic [CW-1:0] evt = 4, dma = 4;
  logic port_req = 0, host_ack = 0, host_rd = 0, cpu_rd = 0;
  logic port_rd, host_req;
  logic [31:0] port_data, rd_data;
  int checks = 0, errors = 0, cycles = 0;
  string tag = "R7";

  always #4 clk = ~clk;

  rx_pacer_fifo #(.DATA_W(32), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_evt_count(evt),
    .cfg_dma_count(dma), .port_req(port_req), .port_rd(port_rd),
    .port_data(port_data), .host_req(host_req), .host_ack(host_ack),
    .host_rd(host_rd), .cpu_rd(cpu_rd), .rd_data(rd_data));

  always @(posedge clk)
    if (!rst_n) port_data <= 32'hC0DE_0000;
    else if (port_rd) port_data <= port_data + 1;

  logic [31:0] mq[$];
  int m_fetch = 0, m_left = 0;
  bit m_pend = 0, m_hreq = 0, m_busy = 0;

  always @(posedge clk) begin : model
    int cnt;
    bit st;
    if (!rst_n || !en) begin
      mq.delete(); m_fetch = 0; m_left = 0; m_pend = 0; m_hreq = 0; m_busy = 0;
    end else begin
      cnt = mq.size();
      st = m_pend && m_fetch == 0 && (DEPTH - cnt) >= int'(dma);
      if ((host_rd || cpu_rd) && cnt > 0) void'(mq.pop_front());
      if (m_fetch > 0) mq.push_back(port_data);
      if (!m_hreq && !m_busy && evt != 0 && cnt >= int'(evt)) m_hreq = 1;
      else if (m_hreq && host_ack) begin m_hreq = 0; m_busy = 1; m_left = int'(evt); end
      else if (m_busy && host_rd && cnt > 0) begin
        if (m_left <= 1) m_busy = 0;
        m_left--;
      end
      if (st) m_fetch = int'(dma); else if (m_fetch > 0) m_fetch--;
      m_pend = st ? port_req : (m_pend | port_req);
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] e_data;
    e_data = !en ? port_data : (mq.size() > 0 ? mq[0] : 32'h0);
    chk(tag, "port_rd", 32'(port_rd), 32'(en ? (m_fetch > 0) : host_rd));
    chk(tag, "host_req", 32'(host_req), 32'(en ? m_hreq : port_req));
    chk(tag, "rd_data", rd_data, e_data);
  endtask

  task automatic step(input logic preq, hrd, hack, crd);
    @(negedge clk);
    port_req = preq; host_rd = hrd; host_ack = hack; cpu_rd = crd;
    #1 compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic host_burst(input int n);
    for (int i = 0; i < 40 && !m_hreq; i++) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R7";
    idle(3);
    chk("R7", "reset host_req", 32'(host_req), 0);
    chk("R7", "reset port_rd", 32'(port_rd), 0);
    chk("R7", "reset rd_data", rd_data, 0);
    @(negedge clk) rst_n = 1;

    tag = "R1"; en = 0;
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(1, 1, 0, 0); step(0, 0, 0, 0);
    @(negedge clk) en = 1;

    tag = "R2"; dma = 4; evt = 4;
    step(1, 0, 0, 0); idle(7);
    tag = "R9"; host_burst(4); idle(4);
    step(1, 0, 0, 0); idle(7); host_burst(4); idle(3);

    tag = "R5"; dma = 2; evt = 6;
    for (int k = 0; k < 6; k++) begin step(1, 0, 0, 0); idle(4); end
    host_burst(6); idle(3);
    tag = "R4"; idle(3); host_burst(6); idle(3);

    tag = "R3"; dma = 4; evt = 16;
    for (int k = 0; k < 4; k++) begin step(1, 0, 0, 0); idle(6); end
    step(1, 0, 0, 0); idle(3);
    tag = "R8"; step(1, 0, 0, 0); idle(1); step(1, 0, 0, 0);
    tag = "R3";
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
    idle(3); step(0, 0, 0, 1); idle(8);
    tag = "R8"; idle(6);

    @(negedge clk) en = 0;
    @(negedge clk) en = 1;
    tag = "R6"; dma = 3; evt = 8;
    step(1, 0, 0, 0); idle(6);
    step(0, 1, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    tag = "R7"; step(0, 0, 0, 1); step(0, 1, 0, 1);
    chk("R7", "empty read data", rd_data, 0);
    idle(2);
    chk("R7", "empty host_req", 32'(host_req), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule